// File: doc/BRIEF.md
# Banked GPIO Controller with Masked Half-Word Writes

This block is a memory-mapped general-purpose I/O controller for a set of pad banks, each up to 32 pins wide. For every bank it holds a direction register, an output-enable register and an output data register. It drives one output vector and one output-enable vector for each bank and samples one input vector for each bank. A simple synchronous register bus reaches all of this state: address, write strobe, write data and registered read data.

The output data of a bank is never written as a whole word. Software updates it through two write-only ports, each covering one 16-bit half of the bank. A write to such a port carries a per-bit mask in its upper half and the new values in its lower half. Only the pins whose mask bit is 0 take the new value, so a single pin can be set or cleared in one bus write, without a read-modify-write sequence and without disturbing other pins. Pad inputs pass through a two-flop synchroniser and can be read back through a read-only input register for each bank.

The number of banks is a parameter. The default is 4, so pad vectors are 128 bits wide and bank `b` occupies bits `b*32 +: 32`.

Top module: `banked_gpio`

## Requirements
- R1: The direction register of bank b is read/write at byte address 0x204 + b*0x40. A write stores all 32 bits, and a read returns the stored value.
- R2: The output-enable register of bank b is read/write at byte address 0x208 + b*0x40. A write stores all 32 bits, and a read returns the stored value.
- R3: Pad output-enable bit b*32+p is 1 only when both the direction bit p and the output-enable bit p of bank b are 1. Pad output bit b*32+p equals the stored output data bit p of bank b.
- R4: A write to the low mask/data port of bank b (address b*0x08) treats bits 31:16 as a mask and bits 15:0 as data for pins 0 to 15. Pin p takes data bit p when mask bit 16+p is 0 and otherwise keeps its value. Example: 0xFFFE0001 drives pin 0 high, 0xFFFE0000 drives it low, and 0xFFFB0004 drives pin 2 high.
- R5: A write to the high mask/data port of bank b (address b*0x08 + 0x04) works in the same way for pins 16 to 31. Data bit k and mask bit 16+k control pin 16+k.
- R6: A write to any register of one bank leaves all other banks unchanged. A write to a direction or output-enable register leaves the output data unchanged.
- R7: The input register of bank b at address 0x40 + b*0x04 is read-only and returns the pad inputs of that bank after two synchronising flops. A pad change is not visible in a read issued on the next cycle, but it is visible a few cycles later.
- R8: Reset, synchronous and active low, clears all direction, output-enable, output data and synchroniser state, so every pad starts as an undriven input with output value 0.
- R9: Reads of the mask/data ports and of unmapped addresses return zero.
- R10: Writes take effect at the clock edge on which the write strobe is sampled. Read data for an address appears on the read data port one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (12) | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the address of the previous cycle |
| pad_out | output | NUM_BANKS*32 (128) | Output values to the pads |
| pad_oe | output | NUM_BANKS*32 (128) | Pad driver enables, 1 = driven |
| pad_in | input | NUM_BANKS*32 (128) | Raw pad input values |

## Verification
The assertions check two things on every cycle. First, after any write to a mask/data port, the pins whose mask bit is 1 hold their previous value. Second, writes to configuration registers never disturb the output data, and reads of the write-only ports return zero. The bench scenarios are the only evidence for the rest: exact address placement across banks with the two different strides, the behaviour of particular mask/data write values, the combined gating of direction and enable on the pads, isolation between banks, the synchroniser latency seen through reads, and clearing by reset in the middle of a run.

// File: rtl/banked_gpio_pkg.sv
// Package: shared address-map constants and the masked-merge helper.
// Assumes byte addressing with 32-bit registers.
package banked_gpio_pkg;
    localparam int BANK_W      = 32;
    localparam int HALF_W      = 16;
    localparam int MD_STRIDE   = 'h08;   // mask/data ports: stride between banks
    localparam int MD_HI_OFS   = 'h04;   // offset of the upper-half port
    localparam int CFG_STRIDE  = 'h40;   // direction/enable: stride between banks
    localparam int DIR_BASE    = 'h204;
    localparam int OEN_BASE    = 'h208;
    localparam int IN_BASE     = 'h40;
    localparam int IN_STRIDE   = 'h04;

    // Keep old bits where mask is 1, take new data where mask is 0.
    function automatic logic [HALF_W-1:0] masked_merge(
        input logic [HALF_W-1:0] old_v,
        input logic [HALF_W-1:0] mask,
        input logic [HALF_W-1:0] data);
        return (old_v & mask) | (data & ~mask);
    endfunction
endpackage

// File: rtl/gpio_sync2.sv
// Module: two-flop synchroniser for a vector of asynchronous pad inputs.
// Assumes each bit is independent (no multi-bit coherence required).
module gpio_sync2 #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] meta_q;

    // Two-stage capture with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q_sync <= '0;
        end else begin
            meta_q <= d_async;
            q_sync <= meta_q;
        end
    end
endmodule

// File: rtl/gpio_bank.sv
// Module: one pad bank. It decodes its own direction, enable and mask/data
// port addresses and holds the three registers of the bank.
// Assumes that the write address and data are stable in the cycle of bus_we.
module gpio_bank
    import banked_gpio_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int BANK_IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    output logic [BANK_W-1:0] dir_q,
    output logic [BANK_W-1:0] oen_q,
    output logic [BANK_W-1:0] dout_q,
    output logic [BANK_W-1:0] drive_en
);
    localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'(DIR_BASE + BANK_IDX*CFG_STRIDE);
    localparam logic [ADDR_W-1:0] A_OEN = ADDR_W'(OEN_BASE + BANK_IDX*CFG_STRIDE);
    localparam logic [ADDR_W-1:0] A_MLO = ADDR_W'(BANK_IDX*MD_STRIDE);
    localparam logic [ADDR_W-1:0] A_MHI = ADDR_W'(BANK_IDX*MD_STRIDE + MD_HI_OFS);

    logic hit_dir, hit_oen, hit_lo, hit_hi;

    // Write-select decode for this bank.
    always_comb begin
        hit_dir = wr_en && (wr_addr == A_DIR);
        hit_oen = wr_en && (wr_addr == A_OEN);
        hit_lo  = wr_en && (wr_addr == A_MLO);
        hit_hi  = wr_en && (wr_addr == A_MHI);
    end

    // Configuration registers: full-word writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '0;
            oen_q <= '0;
        end else begin
            if (hit_dir) dir_q <= wr_data;
            if (hit_oen) oen_q <= wr_data;
        end
    end

    // Output data: each half is updated through its masked port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q <= '0;
        end else begin
            if (hit_lo)
                dout_q[HALF_W-1:0] <= masked_merge(dout_q[HALF_W-1:0],
                                                   wr_data[31:16], wr_data[15:0]);
            if (hit_hi)
                dout_q[BANK_W-1:HALF_W] <= masked_merge(dout_q[BANK_W-1:HALF_W],
                                                        wr_data[31:16], wr_data[15:0]);
        end
    end

    // Pad driver gating: a pin is driven only as an enabled output.
    assign drive_en = dir_q & oen_q;

    // R4: masked low-half pins hold their value.
    a_r4_low_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        hit_lo |=> (((dout_q[15:0] ^ $past(dout_q[15:0])) & $past(wr_data[31:16])) == '0));

    // R5: masked high-half pins hold their value.
    a_r5_high_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        hit_hi |=> (((dout_q[31:16] ^ $past(dout_q[31:16])) & $past(wr_data[31:16])) == '0));

    // R6: a configuration write never alters the output data.
    a_r6_cfg_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_dir || hit_oen) |=> $stable(dout_q));
endmodule

// File: rtl/banked_gpio.sv
// Module: top of the banked GPIO controller. It instantiates one bank per
// NUM_BANKS plus an input synchroniser per bank, and registers the read mux.
// Assumes a single-cycle register bus with read data one cycle later.
module banked_gpio
    import banked_gpio_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic                        bus_we,
    input  logic [31:0]                 bus_wdata,
    output logic [31:0]                 bus_rdata,
    output logic [NUM_BANKS*BANK_W-1:0] pad_out,
    output logic [NUM_BANKS*BANK_W-1:0] pad_oe,
    input  logic [NUM_BANKS*BANK_W-1:0] pad_in
);
    localparam int PAD_W = NUM_BANKS * BANK_W;

    logic [BANK_W-1:0] dir_a  [NUM_BANKS];
    logic [BANK_W-1:0] oen_a  [NUM_BANKS];
    logic [BANK_W-1:0] dout_a [NUM_BANKS];
    logic [BANK_W-1:0] din_a  [NUM_BANKS];
    logic [31:0]       rd_next;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        gpio_bank #(.ADDR_W(ADDR_W), .BANK_IDX(b)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (bus_we),
            .wr_addr  (bus_addr),
            .wr_data  (bus_wdata),
            .dir_q    (dir_a[b]),
            .oen_q    (oen_a[b]),
            .dout_q   (dout_a[b]),
            .drive_en (pad_oe[b*BANK_W +: BANK_W])
        );
        gpio_sync2 #(.W(BANK_W)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .d_async (pad_in[b*BANK_W +: BANK_W]),
            .q_sync  (din_a[b])
        );
        assign pad_out[b*BANK_W +: BANK_W] = dout_a[b];
    end

    // Read decode: readable registers only; the rest return zero.
    always_comb begin
        rd_next = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bus_addr == ADDR_W'(DIR_BASE + b*CFG_STRIDE)) rd_next = dir_a[b];
            if (bus_addr == ADDR_W'(OEN_BASE + b*CFG_STRIDE)) rd_next = oen_a[b];
            if (bus_addr == ADDR_W'(IN_BASE + b*IN_STRIDE))   rd_next = din_a[b];
        end
    end

    // Registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n) bus_rdata <= '0;
        else        bus_rdata <= rd_next;
    end

    // R9: the write-only mask/data ports read back as zero.
    a_r9_wo_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr < ADDR_W'(NUM_BANKS*MD_STRIDE)) |=> (bus_rdata == '0));

    // R3: a driven pad always has a valid width-aligned vector (no X on enables).
    a_r3_oe_known: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(pad_oe) && ($countones(pad_oe) <= PAD_W));
endmodule

// File: tb/sim_banked_gpio.sv
`timescale 1ns/1ps
module sim_banked_gpio;
    localparam int NB = 4;
    localparam int AW = 12;

    logic            clk = 0;
    logic            rst_n = 0;
    logic [AW-1:0]   bus_addr = '0;
    logic            bus_we = 0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NB*32-1:0] pad_out, pad_oe;
    logic [NB*32-1:0] pad_in = '0;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_issue = 0;
    logic        rd_issue_d = 0;

    always #2.5 clk = ~clk;

    banked_gpio #(.NUM_BANKS(NB), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_in(pad_in));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // Driver: write one register.
    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1; bus_wdata = d;
        @(negedge clk);
        bus_we = 0;
    endtask

    // Driver: present a read address and push the expected value.
    task automatic rd(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        bus_addr = a; bus_we = 0;
        exp_q.push_back(e); tag_q.push_back(tag);
        rd_issue = 1;
        @(negedge clk);
        rd_issue = 0;
    endtask

    // Monitor: one cycle after an issued read, compare against the queue.
    always @(posedge clk) rd_issue_d <= rd_issue;
    always @(negedge clk) begin
        if (rd_issue_d && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, bus_rdata, e);
        end
    end

    function automatic logic [31:0] bank(input logic [NB*32-1:0] v, input int b);
        return v[b*32 +: 32];
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8 pad_oe reset", bank(pad_oe, 2), 32'h0);
        check("R8 pad_out reset", bank(pad_out, 2), 32'h0);
        rst_n = 1;
        rd(12'h204, 32'h0, "R8 dir0 after reset");

        // R1/R2: configuration registers of bank 2
        wr(12'h284, 32'h0000_000F);
        rd(12'h284, 32'h0000_000F, "R1 dir bank2 readback");
        wr(12'h288, 32'h0000_0005);
        rd(12'h288, 32'h0000_0005, "R2 oen bank2 readback");
        rd(12'h244, 32'h0, "R1 dir bank1 untouched");

        // R4: low-half masked writes
        wr(12'h010, 32'hFFFE_0001);
        check("R4 pin0 high", bank(pad_out, 2), 32'h0000_0001);
        check("R3 oe gated by dir and enable", bank(pad_oe, 2), 32'h0000_0005);
        wr(12'h010, 32'hFFFB_0004);
        check("R4 pin2 high others kept", bank(pad_out, 2), 32'h0000_0005);
        wr(12'h010, 32'hFFFE_0000);
        check("R4 pin0 low", bank(pad_out, 2), 32'h0000_0004);
        wr(12'h010, 32'hFFFF_1234);
        check("R4 full mask no change", bank(pad_out, 2), 32'h0000_0004);

        // R5: high-half port
        wr(12'h014, 32'h7FFF_8000);
        check("R5 pin31 high", bank(pad_out, 2), 32'h8000_0004);
        wr(12'h014, 32'h0000_00A5);
        check("R5 unmasked half", bank(pad_out, 2), 32'h00A5_0004);

        // R6: bank isolation and config writes keep data
        wr(12'h000, 32'h0000_FFFF);
        check("R6 bank0 written", bank(pad_out, 0), 32'h0000_FFFF);
        check("R6 bank2 unchanged", bank(pad_out, 2), 32'h00A5_0004);
        check("R3 bank0 undriven", bank(pad_oe, 0), 32'h0);
        wr(12'h284, 32'hFFFF_FFFF);
        check("R6 dir write keeps data", bank(pad_out, 2), 32'h00A5_0004);
        check("R3 oe follows enable", bank(pad_oe, 2), 32'h0000_0005);
        wr(12'h2C8, 32'h1);
        check("R6 bank3 enable keeps bank2", bank(pad_oe, 2), 32'h0000_0005);

        // R9: write-only and unmapped reads
        rd(12'h010, 32'h0, "R9 mask port reads zero");
        rd(12'h3FC, 32'h0, "R9 unmapped reads zero");

        // R7/R10: input synchroniser latency
        @(negedge clk);
        pad_in = '0;
        pad_in[2*32 +: 32] = 32'hCAFE_0042;
        rd(12'h048, 32'h0, "R7 input not yet visible");
        repeat (3) @(negedge clk);
        rd(12'h048, 32'hCAFE_0042, "R7 input after sync");
        rd(12'h044, 32'h0, "R7 other bank input");

        // R8: reset mid-run clears everything
        @(negedge clk);
        rst_n = 0;
        repeat (2) @(negedge clk);
        check("R8 reset clears out", bank(pad_out, 2), 32'h0);
        check("R8 reset clears oe", bank(pad_oe, 2), 32'h0);
        rst_n = 1;
        rd(12'h284, 32'h0, "R8 dir cleared");
        repeat (2) @(negedge clk);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule